// File: doc/BRIEF.md
# Converter Interrupt Flag and Vector Encoder

This block sits beside an analog-to-digital converter's result slots and turns their events into one interrupt request and one prioritized vector word. It holds a ready flag for each result slot plus two error flags. The first error flag records that a new result landed in a slot whose previous result was never read. The second records that a conversion was started before the prior one finished. Each flag is masked by its own enable. The two error flags are also masked by a global enable. The highest-priority pending source is then encoded as a small even number.

The processor reads the vector word to find out which source needs service. Reading the vector acknowledges the two error sources. Result-ready flags stay set until the slot's result is read. The slot logic raises single-cycle pulses when a result is written, when a result is read and when a late start occurs. Enables are plain level inputs held by a register file elsewhere.

Top module: `adc_irq_vector`

## Requirements
- R1: After reset every flag is clear, `vec_word` is 0 and `irq` is low.
- R2: With no enabled source pending, `vec_word` is 0, even when masked flags are set.
- R3: A pending, enabled ready flag of slot n (n = 0..15), when it is the winning source, gives `vec_word` = 0x06 + 2n (0x06 for slot 0, 0x24 for slot 15).
- R4: The overwrite error encodes as 0x02 and the late-start error as 0x04.
- R5: When several enabled sources are pending, the lowest nonzero code wins: overwrite, then late start, then slot 0 up to slot 15.
- R6: A `result_done[n]` pulse sets slot n's ready flag and a `result_read[n]` pulse clears it, both visible in the cycle after the edge. If both pulses arrive in the same cycle, the flag stays set.
- R7: `slot_en[n]` masks only slot n's contribution. A masked flag is kept and reappears in the vector once its enable returns.
- R8: The overwrite source is visible only when both `ovr_en` and `glb_en` are high. The late-start source is visible only when both `late_en` and `glb_en` are high. Their flags are retained while masked.
- R9: A `vec_rd` pulse clears the overwrite flag only if `vec_word` read 0x02 in that cycle, and clears the late-start flag only if it read 0x04. It never clears a ready flag.
- R10: A `result_done[n]` pulse while slot n's flag is set and no `result_read[n]` arrives in the same cycle sets the overwrite flag.
- R11: `irq` is high exactly when `vec_word` is nonzero.
- R12: A `late_start` pulse sets the late-start flag. When a set and a vector-read clear of the same error flag coincide, the flag stays set. This applies to both error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| result_done | input | 16 | Per-slot pulse: a new result was written |
| result_read | input | 16 | Per-slot pulse: the slot's result was read |
| late_start | input | 1 | Pulse: conversion began before the previous one completed |
| slot_en | input | 16 | Per-slot enable for the ready flags |
| ovr_en | input | 1 | Enable for the overwrite error source |
| late_en | input | 1 | Enable for the late-start error source |
| glb_en | input | 1 | Global enable applied to both error sources |
| vec_rd | input | 1 | Pulse: the vector word is being read this cycle |
| vec_word | output | 16 | Encoded highest-priority pending source, 0 when none |
| irq | output | 1 | Interrupt request, high while any enabled source is pending |

## Verification
A wrong flag shows at the ports no later than the cycle after the edge that should have changed it. This requires the flag to be enabled and to be the winning source, so the bench steers enables and priorities to put each flag in front in turn. A vector read that clears the wrong source is exposed in the next cycle, when the next vector value either repeats or skips a source. A missed overwrite only shows when the overwrite source outranks every ready flag, which it always does while its enables are on. A reference model checks both outputs on every cycle during directed and random stimulus.

// File: rtl/irqvec_pkg.sv
package irqvec_pkg;

  // Source index layout used by the encoder: 0 = overwrite error,
  // 1 = late-start error, 2.. = result slots in ascending order.
  localparam int SRC_OVR  = 0;
  localparam int SRC_LATE = 1;
  localparam int SRC_SLOT0 = 2;

  typedef struct packed {
    logic ovr;
    logic late;
  } err_flags_t;

  // Vector code of a source index: nonzero, even, ascending with index.
  function automatic int src_code(input int idx);
    return 2 * (idx + 1);
  endfunction

endpackage

// File: rtl/irqvec_slot_flags.sv
module irqvec_slot_flags #(
  parameter int N_SLOTS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SLOTS-1:0] result_done,
  input  logic [N_SLOTS-1:0] result_read,
  output logic [N_SLOTS-1:0] slot_flags,
  output logic               ovr_event
);

  logic [N_SLOTS-1:0] ovr_hit;

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    // A new result takes precedence over a read in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              slot_flags[i] <= 1'b0;
      else if (result_done[i]) slot_flags[i] <= 1'b1;
      else if (result_read[i]) slot_flags[i] <= 1'b0;
    end

    // The unread result is lost only if nobody reads it this cycle.
    assign ovr_hit[i] = result_done[i] & slot_flags[i] & ~result_read[i];
  end

  assign ovr_event = |ovr_hit;

endmodule

// File: rtl/irqvec_err_flags.sv
module irqvec_err_flags
  import irqvec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovr_event,
  input  logic       late_event,
  input  logic       clr_ovr,
  input  logic       clr_late,
  output err_flags_t errs
);

  // Set wins over an acknowledge in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      errs <= '0;
    end else begin
      errs.ovr  <= ovr_event  | (errs.ovr  & ~clr_ovr);
      errs.late <= late_event | (errs.late & ~clr_late);
    end
  end

endmodule

// File: rtl/irqvec_prio_enc.sv
module irqvec_prio_enc
  import irqvec_pkg::*;
#(
  parameter int N_SRC = 18,
  parameter int VEC_W = 16
) (
  input  logic [N_SRC-1:0] pend,
  output logic [VEC_W-1:0] vec,
  output logic             any
);

  // Scan from the lowest priority upward so the lowest index is kept.
  always_comb begin
    vec = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend[i]) vec = VEC_W'(src_code(i));
    end
  end

  assign any = |pend;

endmodule

// File: rtl/adc_irq_vector.sv
module adc_irq_vector
  import irqvec_pkg::*;
#(
  parameter int N_SLOTS = 16,
  parameter int VEC_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SLOTS-1:0] result_done,
  input  logic [N_SLOTS-1:0] result_read,
  input  logic               late_start,
  input  logic [N_SLOTS-1:0] slot_en,
  input  logic               ovr_en,
  input  logic               late_en,
  input  logic               glb_en,
  input  logic               vec_rd,
  output logic [VEC_W-1:0]   vec_word,
  output logic               irq
);

  localparam int N_SRC = N_SLOTS + SRC_SLOT0;
  localparam logic [VEC_W-1:0] CODE_OVR  = VEC_W'(src_code(SRC_OVR));
  localparam logic [VEC_W-1:0] CODE_LATE = VEC_W'(src_code(SRC_LATE));

  logic [N_SLOTS-1:0] slot_flags;
  logic               ovr_event;
  logic               clr_ovr;
  logic               clr_late;
  err_flags_t         errs;
  logic               ovr_flag;
  logic               late_flag;
  logic [N_SRC-1:0]   pend;

  irqvec_slot_flags #(.N_SLOTS(N_SLOTS)) u_slots (
    .clk         (clk),
    .rst_n       (rst_n),
    .result_done (result_done),
    .result_read (result_read),
    .slot_flags  (slot_flags),
    .ovr_event   (ovr_event)
  );

  // Acknowledge only the error source the vector is reporting now.
  assign clr_ovr  = vec_rd && (vec_word == CODE_OVR);
  assign clr_late = vec_rd && (vec_word == CODE_LATE);

  irqvec_err_flags u_errs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ovr_event  (ovr_event),
    .late_event (late_start),
    .clr_ovr    (clr_ovr),
    .clr_late   (clr_late),
    .errs       (errs)
  );

  assign ovr_flag  = errs.ovr;
  assign late_flag = errs.late;

  assign pend[SRC_OVR]  = ovr_flag  & ovr_en  & glb_en;
  assign pend[SRC_LATE] = late_flag & late_en & glb_en;
  assign pend[N_SRC-1:SRC_SLOT0] = slot_flags & slot_en;

  irqvec_prio_enc #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_enc (
    .pend (pend),
    .vec  (vec_word),
    .any  (irq)
  );

endmodule

// File: rtl/irqvec_checker.sv
module irqvec_checker #(
  parameter int N_SLOTS = 16,
  parameter int VEC_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_SLOTS-1:0] result_done,
  input logic [N_SLOTS-1:0] result_read,
  input logic               glb_en,
  input logic               vec_rd,
  input logic [VEC_W-1:0]   vec_word,
  input logic               irq,
  input logic [N_SLOTS-1:0] slot_flags,
  input logic               ovr_flag
);

  AST_IRQ_MATCHES_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (vec_word != '0)); // R11

  AST_VEC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    vec_word[0] == 1'b0); // R3

  AST_OVR_ON_LOST_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (|(result_done & slot_flags & ~result_read)) |=> ovr_flag); // R10

  AST_ERR_NEED_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> (vec_word != VEC_W'(2) && vec_word != VEC_W'(4))); // R8

  AST_VEC_RD_KEEPS_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd |=> ((($past(slot_flags) & ~$past(result_read)) & ~slot_flags) == '0)); // R9

  AST_READ_CLEARS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (|(result_read & ~result_done)) |=>
      ((slot_flags & $past(result_read & ~result_done)) == '0)); // R6

endmodule

bind adc_irq_vector irqvec_checker #(.N_SLOTS(N_SLOTS), .VEC_W(VEC_W)) u_chk (.*);

// File: tb/tb_adc_irq_vector.sv
`timescale 1ns/1ps
module tb_adc_irq_vector;

  localparam int NS = 16;
  localparam int VW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] result_done = '0;
  logic [NS-1:0] result_read = '0;
  logic          late_start = 1'b0;
  logic [NS-1:0] slot_en = '0;
  logic          ovr_en = 1'b0;
  logic          late_en = 1'b0;
  logic          glb_en = 1'b0;
  logic          vec_rd = 1'b0;
  logic [VW-1:0] vec_word;
  logic          irq;

  always #2.5 clk = ~clk;

  adc_irq_vector #(.N_SLOTS(NS), .VEC_W(VW)) dut (.*);

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // Behavioural reference state
  bit m_ready[NS];
  bit m_ovr;
  bit m_late;

  function automatic int model_vec();
    if (m_ovr && ovr_en && glb_en) return 2;
    if (m_late && late_en && glb_en) return 4;
    for (int n = 0; n < NS; n++)
      if (m_ready[n] && slot_en[n]) return 6 + 2 * n;
    return 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge: compare, drive, advance one cycle, update model.
  task automatic cycle(input logic [NS-1:0] d, input logic [NS-1:0] r,
                       input logic lt, input logic vr);
    int ev;
    bit lost;
    ev = model_vec();
    chk("R5 vector vs model", int'(vec_word), ev);
    chk("R11 irq vs vector", int'(irq), (ev != 0) ? 1 : 0);
    result_done = d; result_read = r; late_start = lt; vec_rd = vr;
    @(posedge clk);
    lost = 0;
    for (int n = 0; n < NS; n++) begin
      if (d[n] && m_ready[n] && !r[n]) lost = 1;
      if (d[n]) m_ready[n] = 1;
      else if (r[n]) m_ready[n] = 0;
    end
    m_ovr  = lost | (m_ovr  & !(vr && ev == 2));
    m_late = lt   | (m_late & !(vr && ev == 4));
    @(negedge clk);
    result_done = '0; result_read = '0; late_start = 0; vec_rd = 0;
  endtask

  task automatic idle();
    cycle('0, '0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < NS; n++) m_ready[n] = 0;
    m_ovr = 0; m_late = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset vector", int'(vec_word), 0);
    chk("R1 reset irq", int'(irq), 0);
    rst_n = 1;
    @(negedge clk);

    // R2: flags pending but all enables off
    cycle(16'h0021, '0, 1, 0);
    chk("R2 masked flags give zero vector", int'(vec_word), 0);
    cycle('0, 16'h0021, 0, 0);
    glb_en = 1; late_en = 1;
    @(negedge clk);
    chk("R12 late flag kept while masked", int'(vec_word), 4);
    cycle('0, '0, 0, 1);
    chk("R9 vector read clears late flag", int'(vec_word), 0);

    slot_en = '1; ovr_en = 1;
    @(negedge clk);
    cycle(16'h0020, '0, 0, 0);
    chk("R3 R6 slot 5 code", int'(vec_word), 16'h10);
    cycle('0, 16'h0020, 0, 0);
    chk("R6 read clears slot flag", int'(vec_word), 0);

    cycle(16'h0088, '0, 0, 0);
    chk("R5 slot 3 outranks slot 7", int'(vec_word), 16'h0C);
    cycle(16'h0008, '0, 0, 0);
    chk("R10 R4 overwrite code", int'(vec_word), 2);
    cycle('0, '0, 0, 1);
    chk("R9 overwrite acked, slots kept", int'(vec_word), 16'h0C);
    cycle(16'h0008, 16'h0008, 0, 0);
    chk("R6 R10 done with read keeps flag, no overwrite", int'(vec_word), 16'h0C);

    cycle('0, '0, 1, 0);
    chk("R4 R12 late-start code", int'(vec_word), 4);
    glb_en = 0;
    @(negedge clk);
    chk("R8 global enable masks late start", int'(vec_word), 16'h0C);
    glb_en = 1; late_en = 0;
    @(negedge clk);
    chk("R8 own enable masks late start", int'(vec_word), 16'h0C);
    late_en = 1;
    @(negedge clk);
    cycle('0, '0, 1, 1);
    chk("R12 set wins over vector-read clear", int'(vec_word), 4);
    cycle('0, '0, 0, 1);
    chk("R9 late flag cleared by read", int'(vec_word), 16'h0C);
    cycle('0, '0, 0, 1);
    chk("R9 vector read leaves ready flag", int'(vec_word), 16'h0C);

    slot_en[3] = 0;
    @(negedge clk);
    chk("R7 slot 3 masked, slot 7 wins", int'(vec_word), 16'h14);
    slot_en[3] = 1;
    @(negedge clk);
    chk("R7 masked flag returns", int'(vec_word), 16'h0C);

    cycle('0, 16'h0088, 0, 0);
    cycle(16'h8000, '0, 0, 0);
    chk("R3 slot 15 code", int'(vec_word), 16'h24);
    chk("R11 irq with slot 15", int'(irq), 1);
    cycle(16'h0001, '0, 0, 0);
    chk("R3 R5 slot 0 code", int'(vec_word), 6);
    cycle('0, 16'h8001, 0, 0);
    chk("R11 irq low when idle", int'(irq), 0);

    for (int k = 0; k < 400; k++) begin
      slot_en = NS'($urandom | $urandom);
      ovr_en  = ($urandom % 4) != 0;
      late_en = ($urandom % 4) != 0;
      glb_en  = ($urandom % 5) != 0;
      @(negedge clk);
      cycle(NS'($urandom & $urandom & $urandom), NS'($urandom & $urandom),
            ($urandom % 8) == 0, ($urandom % 3) == 0);
    end
    idle();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule